// File: doc/BRIEF.md
# Eight-Bit Waveform Timer

This block is a counter with one compare channel that drives a single waveform pin. It advances once for every cycle in which the clock-enable `tick` is high. A two-bit mode selects one of four counting schemes. Normal mode counts up freely and wraps. Clear-on-compare mode restarts at zero after reaching the compare value. Fast PWM counts up and wraps. Phase-correct PWM counts up to the all-ones value and then back down to zero.

Software-style writes set the mode, the pin action, the compare value and the counter value. Two sticky flags, compare match and overflow, are cleared by writing ones to a clear mask. The compare value is written into a buffer. In the PWM modes the buffer is applied only at a fixed point of the period, so the duty cycle never changes in the middle of a period. A force strobe applies the pin action of the non-PWM modes at once. It has none of the side effects of a real match.

Top module: `wavegen_timer8`

## Requirements
- R1: After reset, `count` is 0, the compare value and its buffer are 0, the mode is normal, the action is 00, the pin state is 0, and both flags are 0.
- R2: `ctl_mode` encoding: 00 normal, 01 phase-correct PWM, 10 clear-on-compare, 11 fast PWM. Each tick moves the count by one step. Normal and fast PWM wrap from all-ones to 0. Clear-on-compare goes to 0 on the tick taken while `count` equals the active compare value. Phase-correct turns down on the tick taken at all-ones and turns up on the tick taken at 0, so neither end value repeats.
- R3: `match_flag` is set by the clock edge of a tick taken while `count` equals the active compare value. Writing with `flag_clr_wr` clears `match_flag` when bit 0 of `flag_clr` is 1, and clears `ovf_flag` when bit 1 is 1. A flag that is set and cleared in the same cycle ends up set.
- R4: `ovf_flag` is set by a tick taken at all-ones in normal, clear-on-compare and fast PWM modes. In phase-correct mode it is set by the tick taken at 0 while counting down, and never at all-ones.
- R5: A compare write reaches the active compare value at once in normal and clear-on-compare modes. In fast PWM it takes effect on the tick that wraps from all-ones to 0. In phase-correct mode it takes effect on the tick taken at all-ones while counting up.
- R6: In normal and clear-on-compare modes, a match applies `ctl_act`: 01 toggles the pin, 10 clears it, 11 sets it, 00 leaves it alone.
- R7: In fast PWM, action 10 clears the pin on a match and sets it on the wrap to 0. Action 11 does the opposite. When both happen on the same tick, the wrap action wins.
- R8: In phase-correct PWM, action 10 clears the pin on a match while counting up and sets it on a match while counting down. Action 11 does the opposite.
- R9: `wave_oe` is 1 only when `dir_en` is 1, the action is nonzero, and the action is not 01 in a PWM mode. `wave_out` is the pin state while `wave_oe` is 1, and 0 otherwise.
- R10: A control write with `ctl_force` set, in normal or clear-on-compare mode, applies the written action to the pin in that cycle. It sets no flag and does not move or clear the count. In the PWM modes the force has no effect on the pin.
- R11: A counter write loads `count` and suppresses any compare match on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable |
| ctl_wr | input | 1 | Control write strobe |
| ctl_mode | input | 2 | Mode to write |
| ctl_act | input | 2 | Pin action to write |
| ctl_force | input | 1 | Force-compare strobe, valid with `ctl_wr` |
| cmp_wr | input | 1 | Compare buffer write strobe |
| cmp_wdata | input | WIDTH | Compare value |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | WIDTH | Counter value |
| flag_clr_wr | input | 1 | Flag clear strobe |
| flag_clr | input | 2 | Clear mask: bit 0 match, bit 1 overflow |
| dir_en | input | 1 | Pin direction enable |
| count | output | WIDTH | Current count |
| wave_out | output | 1 | Waveform pin value |
| wave_oe | output | 1 | Pin driver enable |
| match_flag | output | 1 | Compare match flag |
| ovf_flag | output | 1 | Overflow flag |

## Verification
The bench builds the block with WIDTH at its default of 8. At that width a full phase-correct sweep, from the top down to zero and back up, takes a few hundred ticks. This puts both turning points within reach, along with the down-count and up-count matches and the deferred compare reload. The same width lets loaded counts sit just below all-ones, so the wrap, the end-of-period reload and the overflow of every mode can be reached in a few ticks.

// File: rtl/wavegen_timer8.sv
module wavegen_timer8 #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctl_wr,
  input  logic [1:0]       ctl_mode,
  input  logic [1:0]       ctl_act,
  input  logic             ctl_force,
  input  logic             cmp_wr,
  input  logic [WIDTH-1:0] cmp_wdata,
  input  logic             cnt_wr,
  input  logic [WIDTH-1:0] cnt_wdata,
  input  logic             flag_clr_wr,
  input  logic [1:0]       flag_clr,
  input  logic             dir_en,
  output logic [WIDTH-1:0] count,
  output logic             wave_out,
  output logic             wave_oe,
  output logic             match_flag,
  output logic             ovf_flag
);
  localparam logic [WIDTH-1:0] MAXV = '1;
  localparam logic [WIDTH-1:0] ZERO = '0;

  typedef enum logic [1:0] {M_NORM = 2'b00, M_PC = 2'b01, M_CTC = 2'b10, M_FAST = 2'b11} mode_t;

  mode_t            mode;
  logic [1:0]       act;
  logic [WIDTH-1:0] cmp_buf, cmp_act;
  logic             up, blk, pin;

  wire pwm     = (mode == M_PC) || (mode == M_FAST);
  wire at_max  = (count == MAXV);
  wire at_zero = (count == ZERO);
  wire hit     = tick && !blk && !cnt_wr && (count == cmp_act);
  wire wrap_b  = tick && !cnt_wr && (mode == M_FAST) && at_max;
  wire reload  = tick && at_max && ((mode == M_FAST) || (mode == M_PC && up));
  wire ovf_evt = tick && !cnt_wr && ((mode == M_PC) ? (!up && at_zero) : at_max);
  wire frc     = ctl_wr && ctl_force && !ctl_mode[0];

  function automatic logic apply(input logic [1:0] a, input logic p);
    case (a)
      2'b01:   apply = ~p;
      2'b10:   apply = 1'b0;
      2'b11:   apply = 1'b1;
      default: apply = p;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_NORM;  act <= 2'b00;
      cmp_buf <= ZERO; cmp_act <= ZERO;
      count <= ZERO;   up <= 1'b1; blk <= 1'b0; pin <= 1'b0;
      match_flag <= 1'b0; ovf_flag <= 1'b0;
    end else begin
      if (ctl_wr) begin
        mode <= mode_t'(ctl_mode);
        act  <= ctl_act;
      end

      if (cmp_wr) cmp_buf <= cmp_wdata;
      if (!pwm && cmp_wr)  cmp_act <= cmp_wdata;
      else if (!pwm)       cmp_act <= cmp_buf;
      else if (reload)     cmp_act <= cmp_buf;

      if (cnt_wr) begin
        count <= cnt_wdata;
        blk   <= 1'b1;
      end else if (tick) begin
        blk <= 1'b0;
        case (mode)
          M_PC: begin
            if (up) count <= at_max  ? count - 1'b1 : count + 1'b1;
            else    count <= at_zero ? count + 1'b1 : count - 1'b1;
            if (up && at_max)        up <= 1'b0;
            else if (!up && at_zero) up <= 1'b1;
          end
          M_CTC:   count <= (count == cmp_act) ? ZERO : count + 1'b1;
          default: count <= count + 1'b1;
        endcase
      end
      if (mode != M_PC && !(ctl_wr && ctl_mode == M_PC)) up <= 1'b1;

      if (frc) pin <= apply(ctl_act, pin);
      else if (mode == M_FAST) begin
        if (wrap_b)   pin <= (act == 2'b10);
        else if (hit) pin <= (act == 2'b11);
      end else if (mode == M_PC) begin
        if (hit) pin <= up ? (act == 2'b11) : (act == 2'b10);
      end else if (hit) pin <= apply(act, pin);

      match_flag <= (match_flag && !(flag_clr_wr && flag_clr[0])) || hit;
      ovf_flag   <= (ovf_flag   && !(flag_clr_wr && flag_clr[1])) || ovf_evt;
    end
  end

  assign wave_oe  = dir_en && (act != 2'b00) && !(pwm && act == 2'b01);
  assign wave_out = wave_oe && pin;

  assert_wrap_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_NORM || mode == M_FAST) && tick && !cnt_wr && !ctl_wr)
      |=> ((count - $past(count)) == WIDTH'(1)));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PC && tick && !cnt_wr && !ctl_wr)
      |=> (((count - $past(count)) == WIDTH'(1)) || (($past(count) - count) == WIDTH'(1))));

  assert_ctc_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_CTC && tick && !cnt_wr && !ctl_wr && count == cmp_act) |=> (count == ZERO));

  assert_hold_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(count));

  assert_match_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> $past(tick));

  assert_reserved_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && act == 2'b01) |-> !wave_oe);

  assert_out_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wave_oe |-> !wave_out);
endmodule

// File: tb/wavegen_timer8_bench.sv
module wavegen_timer8_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic ctl_wr = 1'b0, ctl_force = 1'b0;
  logic [1:0] ctl_mode = 2'b00, ctl_act = 2'b00;
  logic cmp_wr = 1'b0, cnt_wr = 1'b0, flag_clr_wr = 1'b0, dir_en = 1'b1;
  logic [7:0] cmp_wdata = 8'h00, cnt_wdata = 8'h00;
  logic [1:0] flag_clr = 2'b00;
  logic [7:0] count;
  logic wave_out, wave_oe, match_flag, ovf_flag;

  int checks = 0, failures = 0;
  bit done = 0;
  int    q_kind[$];
  int    q_exp[$];
  string q_tag[$];

  wavegen_timer8 #(.WIDTH(8)) u_wavegen_timer8 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ctl_wr(ctl_wr), .ctl_mode(ctl_mode), .ctl_act(ctl_act), .ctl_force(ctl_force),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .flag_clr_wr(flag_clr_wr), .flag_clr(flag_clr), .dir_en(dir_en),
    .count(count), .wave_out(wave_out), .wave_oe(wave_oe),
    .match_flag(match_flag), .ovf_flag(ovf_flag));

  always #4 clk = ~clk;

  localparam int K_CNT = 0, K_OUT = 1, K_OE = 2, K_MF = 3, K_OVF = 4;

  initial begin : monitor
    forever begin
      int k, e, a;
      string t;
      wait (q_kind.size() != 0);
      k = q_kind.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
      case (k)
        K_CNT:   a = int'(count);
        K_OUT:   a = int'(wave_out);
        K_OE:    a = int'(wave_oe);
        K_MF:    a = int'(match_flag);
        default: a = int'(ovf_flag);
      endcase
      checks++;
      if (a != e) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%0h expected=%0h", t, k, a, e);
      end
    end
  end

  task automatic expect_val(input int k, input int e, input string t);
    q_kind.push_back(k); q_exp.push_back(e); q_tag.push_back(t);
    wait (q_kind.size() == 0);
  endtask

  task automatic clk1();
    @(posedge clk); #2;
  endtask

  task automatic setctl(input logic [1:0] m, input logic [1:0] a, input logic f);
    ctl_wr = 1'b1; ctl_mode = m; ctl_act = a; ctl_force = f;
    clk1();
    ctl_wr = 1'b0; ctl_force = 1'b0;
  endtask

  task automatic wcmp(input logic [7:0] v);
    cmp_wr = 1'b1; cmp_wdata = v; clk1(); cmp_wr = 1'b0;
  endtask

  task automatic wcnt(input logic [7:0] v);
    cnt_wr = 1'b1; cnt_wdata = v; clk1(); cnt_wr = 1'b0;
  endtask

  task automatic clrf();
    flag_clr_wr = 1'b1; flag_clr = 2'b11; clk1(); flag_clr_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; clk1();
    end
    tick = 1'b0;
  endtask

  initial begin : watchdog
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) clk1();
    rst_n = 1'b1;
    clk1();
    expect_val(K_CNT, 0, "R1 count");
    expect_val(K_MF, 0, "R1 match");
    expect_val(K_OVF, 0, "R1 ovf");
    expect_val(K_OE, 0, "R1 oe");
    expect_val(K_OUT, 0, "R1 out");

    // normal mode, toggle
    setctl(2'b00, 2'b01, 1'b0);
    expect_val(K_OE, 1, "R9 oe normal toggle");
    wcmp(8'd5);
    ticks(5);
    expect_val(K_CNT, 5, "R2 count up");
    expect_val(K_MF, 0, "R3 no match before");
    ticks(1);
    expect_val(K_CNT, 6, "R2 count up");
    expect_val(K_MF, 1, "R3 match flag");
    expect_val(K_OUT, 1, "R6 toggle");
    clrf();
    expect_val(K_MF, 0, "R3 clear");

    wcnt(8'hFE);
    ticks(1);
    expect_val(K_CNT, 8'hFF, "R11 load");
    expect_val(K_OVF, 0, "R4 no ovf yet");
    ticks(1);
    expect_val(K_CNT, 0, "R2 wrap");
    expect_val(K_OVF, 1, "R4 ovf normal");

    wcnt(8'd5);
    clrf();
    ticks(1);
    expect_val(K_CNT, 6, "R11 count");
    expect_val(K_MF, 0, "R11 match blocked");
    expect_val(K_OUT, 1, "R11 pin unchanged");

    setctl(2'b00, 2'b01, 1'b1);
    expect_val(K_OUT, 0, "R10 force toggle");
    expect_val(K_MF, 0, "R10 no flag");
    expect_val(K_CNT, 6, "R10 count held");

    // clear-on-compare
    setctl(2'b10, 2'b11, 1'b0);
    wcmp(8'd3);
    wcnt(8'd0);
    clrf();
    ticks(3);
    expect_val(K_CNT, 3, "R2 ctc count");
    ticks(1);
    expect_val(K_CNT, 0, "R2 ctc clear");
    expect_val(K_MF, 1, "R5 immediate compare");
    expect_val(K_OUT, 1, "R6 set");
    expect_val(K_OVF, 0, "R4 no ovf ctc");
    clrf();
    ticks(2);
    setctl(2'b10, 2'b10, 1'b1);
    expect_val(K_OUT, 0, "R10 force clear");
    expect_val(K_CNT, 2, "R10 no ctc clear");
    expect_val(K_MF, 0, "R10 no flag ctc");

    // fast PWM
    setctl(2'b11, 2'b11, 1'b0);
    wcnt(8'd1);
    wcmp(8'd6);
    clrf();
    ticks(3);
    expect_val(K_CNT, 4, "R2 fast count");
    expect_val(K_MF, 1, "R5 old compare kept");
    expect_val(K_OUT, 1, "R7 set on match");
    wcnt(8'hFF);
    clrf();
    ticks(1);
    expect_val(K_CNT, 0, "R2 fast wrap");
    expect_val(K_OVF, 1, "R4 ovf fast");
    expect_val(K_OUT, 0, "R7 clear at bottom");
    ticks(6);
    expect_val(K_MF, 0, "R5 new compare");
    ticks(1);
    expect_val(K_MF, 1, "R5 new compare hit");
    expect_val(K_OUT, 1, "R7 set on new match");
    setctl(2'b11, 2'b01, 1'b0);
    expect_val(K_OE, 0, "R9 reserved action");
    expect_val(K_OUT, 0, "R9 out gated");

    // phase-correct PWM
    setctl(2'b01, 2'b11, 1'b0);
    wcmp(8'h10);
    wcnt(8'hFD);
    clrf();
    ticks(3);
    expect_val(K_CNT, 8'hFE, "R2 pc turn at top");
    expect_val(K_OVF, 0, "R4 no ovf at top pc");
    expect_val(K_OUT, 1, "R8 pin before");
    ticks(8'hEE);
    expect_val(K_CNT, 8'h10, "R2 pc down");
    expect_val(K_MF, 0, "R5 reload at top");
    ticks(1);
    expect_val(K_MF, 1, "R5 pc compare");
    expect_val(K_OUT, 0, "R8 down match clear");
    clrf();
    ticks(15);
    expect_val(K_CNT, 0, "R2 pc bottom");
    expect_val(K_OVF, 0, "R4 pc ovf not yet");
    ticks(1);
    expect_val(K_CNT, 1, "R2 pc turn at bottom");
    expect_val(K_OVF, 1, "R4 pc ovf at bottom");
    ticks(15);
    ticks(1);
    expect_val(K_CNT, 8'h11, "R2 pc up");
    expect_val(K_OUT, 1, "R8 up match set");
    setctl(2'b01, 2'b10, 1'b1);
    expect_val(K_OUT, 1, "R10 force ignored pwm");

    dir_en = 1'b0;
    clk1();
    expect_val(K_OE, 0, "R9 dir off");
    expect_val(K_OUT, 0, "R9 dir off out");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule